// File: doc/BRIEF.md
# Raw-Then-Result Repeat Emitter

This block sits between two pipeline stages and holds one entry. It takes a 28-bit word together with a 4-bit opcode. The upper opcode field picks the transform applied to the word: a logical right shift by one, bitwise inversion, or arithmetic negation. The fourth value of that field drops the word. The lower opcode field sets how many copies of the transformed word follow the untouched word.

After a word is accepted, the block first presents the untouched word. It then presents the transformed word zero to three times. Each word stays on the output until the downstream stage acknowledges it. While the entry is occupied, a busy flag tells the upstream stage to hold its data. A two-bit count shows how many transformed words are still to come after the one on the output. The busy flag drops in the same cycle as the acknowledge of the last word, so a new word can be accepted in that cycle with no gap.

Top module: `rpt_emitter`

## Requirements
- R1: While rst_n is low, and after it is released with no input, out_valid, busy, out_left and out_data are all zero. Asserting reset in the middle of a sequence abandons that sequence.
- R2: A word is accepted on a rising edge when in_valid is high, busy is low and in_op[3:2] is not 2'b11. In the next cycle out_valid is high, out_data equals the accepted word and out_left equals in_op[1:0].
- R3: When in_op[3:2] = 2'b00, each result word is the input shifted right by one bit, with a zero entering bit 27.
- R4: When in_op[3:2] = 2'b01, each result word is the bitwise inverse of the input.
- R5: When in_op[3:2] = 2'b10, each result word is the two's complement negation of the input, modulo 2^28.
- R6: When in_op[3:2] = 2'b11, the word is discarded whatever the value of in_op[1:0]. In the next cycle out_valid stays low and busy stays low.
- R7: The number of result words that follow the untouched word equals in_op[1:0] read as an unsigned number (0 to 3). After the last acknowledge, out_valid goes low.
- R8: While out_valid is high and out_ack is low, out_valid, out_data and out_left keep their values on the next cycle.
- R9: out_left gives the number of result words still to send after the word on the output. It drops by one on each acknowledge and reads zero on the final word.
- R10: busy is high whenever out_valid is high, except when out_ack is high while out_left is zero, where busy is low in the same cycle. While busy is high, in_valid has no effect.
- R11: A word presented in the cycle that the final word is acknowledged is accepted, and its untouched value appears on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 28 | Word offered by the upstream stage |
| in_op | input | 4 | [3:2] transform select, [1:0] repeat count |
| in_valid | input | 1 | Upstream offers a word this cycle |
| out_ack | input | 1 | Downstream takes the current output word |
| out_data | output | 28 | Word presented downstream |
| out_valid | output | 1 | out_data holds a word for downstream |
| out_left | output | 2 | Result words still due after the current one |
| busy | output | 1 | Entry occupied; upstream must hold |

## Verification
The hardest situation to reach from the ports is the cycle where the last acknowledge and a new offer coincide. In that cycle busy must fall combinationally and the new word must load without a bubble. The stimulus reaches it by raising in_valid together with the final out_ack, and it does this both with a kept opcode and with a dropped one. The bench also sweeps all sixteen opcodes across edge-value words: zero, all ones, one and the top bit alone. Acknowledges are delayed by varying amounts, and offers are made while busy, to show that held outputs stay put.

// File: rtl/rpt_pkg.sv
`timescale 1ns/1ps
package rpt_pkg;
    localparam int OP_W  = 4;
    localparam int SEL_W = 2;
    localparam int CNT_W = OP_W - SEL_W;

    typedef enum logic [SEL_W-1:0] {
        XF_SHR  = 2'b00,
        XF_INV  = 2'b01,
        XF_NEG  = 2'b10,
        XF_DROP = 2'b11
    } xf_sel_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_RAW  = 2'b01,
        PH_RES  = 2'b10
    } phase_t;
endpackage

// File: rtl/rpt_decode.sv
`timescale 1ns/1ps
module rpt_decode
    import rpt_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    output xf_sel_t          sel,
    output logic [CNT_W-1:0] count,
    output logic             drop
);
    always_comb begin
        sel   = xf_sel_t'(op[OP_W-1:CNT_W]);
        count = op[CNT_W-1:0];
        drop  = (sel == XF_DROP);
    end
endmodule

// File: rtl/rpt_xform.sv
`timescale 1ns/1ps
module rpt_xform
    import rpt_pkg::*;
#(
    parameter int DW = 28
) (
    input  logic [DW-1:0] din,
    input  xf_sel_t       sel,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] inv;
    assign inv = ~din;

    always_comb begin
        unique case (sel)
            XF_SHR:  dout = {1'b0, din[DW-1:1]};
            XF_INV:  dout = inv;
            XF_NEG:  dout = inv + ONE;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/rpt_seq.sv
`timescale 1ns/1ps
module rpt_seq
    import rpt_pkg::*;
#(
    parameter int DW = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    raw_in,
    input  logic [DW-1:0]    res_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             drop_in,
    input  logic             offer,
    input  logic             ack,
    output logic [DW-1:0]    dout,
    output logic             dvalid,
    output logic [CNT_W-1:0] left,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_t           ph;
        logic [DW-1:0]    raw;
        logic [DW-1:0]    res;
        logic [CNT_W-1:0] left;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic    last_ack;
    logic    take;

    always_comb begin
        last_ack = (st_q.ph != PH_IDLE) && ack && (st_q.left == '0);
        full     = (st_q.ph != PH_IDLE) && !last_ack;
        take     = offer && !full && !drop_in;

        st_d = st_q;
        if (st_q.ph != PH_IDLE && ack) begin
            if (st_q.left == '0) begin
                st_d.ph = PH_IDLE;
            end else begin
                st_d.ph   = PH_RES;
                st_d.left = st_q.left - CNT_ONE;
            end
        end
        if (take) begin
            st_d.ph   = PH_RAW;
            st_d.raw  = raw_in;
            st_d.res  = res_in;
            st_d.left = cnt_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, raw: '0, res: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dvalid = (st_q.ph != PH_IDLE);
        left   = st_q.left;
        unique case (st_q.ph)
            PH_RAW:  dout = st_q.raw;
            PH_RES:  dout = st_q.res;
            default: dout = '0;
        endcase
    end

    // R2: an accepted word is shown untouched next cycle
    p_raw_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (dvalid && dout == $past(raw_in) && left == $past(cnt_in)));

    // R6: a dropped opcode from idle leaves the output empty
    p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (offer && !dvalid && drop_in) |=> !dvalid);

    // R8: unacknowledged output is held
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && !ack) |=> (dvalid && $stable(dout) && $stable(left)));

    // R9: count falls by one per acknowledge
    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && ack && left != '0) |=> (dvalid && left == $past(left) - CNT_ONE));

    // R10: never full while empty
    p_full_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> !full);
endmodule

// File: rtl/rpt_emitter.sv
`timescale 1ns/1ps
module rpt_emitter
    import rpt_pkg::*;
#(
    parameter int DW = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    in_data,
    input  logic [OP_W-1:0]  in_op,
    input  logic             in_valid,
    input  logic             out_ack,
    output logic [DW-1:0]    out_data,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_left,
    output logic             busy
);
    xf_sel_t          sel;
    logic [CNT_W-1:0] count;
    logic             drop;
    logic [DW-1:0]    result;

    rpt_decode u_dec (
        .op    (in_op),
        .sel   (sel),
        .count (count),
        .drop  (drop)
    );

    rpt_xform #(.DW(DW)) u_xf (
        .din  (in_data),
        .sel  (sel),
        .dout (result)
    );

    rpt_seq #(.DW(DW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (in_data),
        .res_in  (result),
        .cnt_in  (count),
        .drop_in (drop),
        .offer   (in_valid),
        .ack     (out_ack),
        .dout    (out_data),
        .dvalid  (out_valid),
        .left    (out_left),
        .full    (busy)
    );

    // R10: last acknowledge frees the entry in the same cycle
    p_free_on_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack && out_left == '0) |-> !busy);
endmodule

// File: tb/test_rpt_emitter.sv
`timescale 1ns/1ps
module test_rpt_emitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] in_data = '0;
    logic [3:0]  in_op = '0;
    logic        in_valid = 1'b0;
    logic        out_ack = 1'b0;
    logic [27:0] out_data;
    logic        out_valid;
    logic [1:0]  out_left;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rpt_emitter i_rpt_emitter (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_op(in_op),
        .in_valid(in_valid), .out_ack(out_ack), .out_data(out_data),
        .out_valid(out_valid), .out_left(out_left), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [27:0] expect_res(input logic [27:0] d, input logic [3:0] o);
        case (o[3:2])
            2'b00:   return d / 28'd2;
            2'b01:   return 28'hFFFFFFF - d;
            2'b10:   return 28'd0 - d;
            default: return 28'd0;
        endcase
    endfunction

    function automatic string res_req(input logic [3:0] o);
        case (o[3:2])
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // called at a falling edge with the entry free
    task automatic send(input logic [27:0] d, input logic [3:0] o);
        in_data = d; in_op = o; in_valid = 1'b1;
        #1 chk(busy == 1'b0, "R10 idle not busy", 28'(busy), 28'd0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // called at the falling edge after the word was taken
    task automatic drain(input logic [27:0] d, input logic [3:0] o, input int hold,
                         input bit chain, input logic [27:0] cd, input logic [3:0] co);
        int n;
        #1;
        if (o[3:2] == 2'b11) begin
            chk(out_valid == 1'b0, "R6 dropped no output", 28'(out_valid), 28'd0);
            chk(busy == 1'b0, "R6 dropped not busy", 28'(busy), 28'd0);
            return;
        end
        n = int'(o[1:0]);
        for (int k = 0; k <= n; k++) begin
            logic [27:0] ew;
            ew = (k == 0) ? d : expect_res(d, o);
            if (k > 0) #1;
            chk(out_valid == 1'b1, "R2 valid", 28'(out_valid), 28'd1);
            chk(out_data == ew, (k == 0) ? "R2 raw first" : res_req(o), out_data, ew);
            chk(out_left == 2'(n - k), "R9 remaining", 28'(out_left), 28'(n - k));
            for (int h = 0; h < hold; h++) begin
                chk(busy == 1'b1, "R10 busy while held", 28'(busy), 28'd1);
                in_valid = 1'b1; in_data = ~d; in_op = 4'b0011;
                @(negedge clk);
                #1;
                in_valid = 1'b0;
                chk(out_valid == 1'b1 && out_data == ew, "R8 held data", out_data, ew);
                chk(out_left == 2'(n - k), "R8 held count", 28'(out_left), 28'(n - k));
            end
            out_ack = 1'b1;
            if (k == n && chain) begin
                in_valid = 1'b1; in_data = cd; in_op = co;
            end
            #0.5;
            chk(busy == (k != n), "R10 busy vs last ack", 28'(busy), 28'(k != n));
            @(negedge clk);
            out_ack = 1'b0; in_valid = 1'b0;
        end
        if (!chain) begin
            #1;
            chk(out_valid == 1'b0, "R7 sequence length", 28'(out_valid), 28'd0);
            chk(busy == 1'b0, "R7 free after sequence", 28'(busy), 28'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [27:0] pats [5];
        pats[0] = 28'h0000000; pats[1] = 28'hFFFFFFF; pats[2] = 28'h0000001;
        pats[3] = 28'h8000000; pats[4] = 28'h5A3C96E;

        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 0 && busy == 0 && out_left == 0 && out_data == 0,
            "R1 in reset", out_data, 28'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 0 && busy == 0 && out_left == 0 && out_data == 0,
            "R1 after reset", out_data, 28'd0);
        @(negedge clk);

        // full sweep of opcodes over edge patterns and ack delays
        for (int o = 0; o < 16; o++) begin
            for (int p = 0; p < 5; p++) begin
                send(pats[p] ^ 28'(o * 28'h0111111 * (p == 4)), 4'(o));
                drain(pats[p] ^ 28'(o * 28'h0111111 * (p == 4)), 4'(o), (o + p) % 3, 1'b0, '0, '0);
            end
        end

        // R11 back-to-back with kept opcode, then with a dropped one
        send(28'h1234567, 4'b0110);
        drain(28'h1234567, 4'b0110, 1, 1'b1, 28'hABCDEF0, 4'b1011);
        drain(28'hABCDEF0, 4'b1011, 0, 1'b1, 28'h0F0F0F0, 4'b1101);
        drain(28'h0F0F0F0, 4'b1101, 0, 1'b0, '0, '0);
        @(negedge clk);
        send(28'h0000002, 4'b0000);
        drain(28'h0000002, 4'b0000, 0, 1'b1, 28'h7777777, 4'b0001);
        drain(28'h7777777, 4'b0001, 2, 1'b0, '0, '0);

        // R1 reset during a sequence
        send(28'h3333333, 4'b0111);
        rst_n = 1'b0;
        #1;
        chk(out_valid == 0 && busy == 0 && out_left == 0, "R1 mid-sequence reset",
            28'(out_valid), 28'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 0 && busy == 0, "R1 stays idle", 28'(out_valid), 28'd0);
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule